// File: doc/BRIEF.md
# Dual-Radix Compound Mantissa Adder

This block adds two mantissas of `DIGITS` four-bit slices. A radix input chooses how the slices are read: as packed BCD digits, or as one plain binary number. A single carry-select datapath serves both radices. In one pass it produces three results: the sum, the sum plus one, and the inverted sum. It also returns the carry-out of a chain seeded with carry-in 0 and of a chain seeded with carry-in 1.

When the effective-subtract input is set, the second operand is complemented before the addition. The carry-out of the carry-in-1 chain then acts as the end-around carry: it tells whether A is at least B. A select stage uses it to return the magnitude of the difference directly.

Inputs are sampled on a clock edge when the valid strobe is high. Every result is registered and appears one clock later.

Top module: `dual_radix_adder`

## Requirements
- R1: After reset, and before any valid input has been sampled, `resValid`, every result bus and every carry output read zero.
- R2: `resValid` is high in exactly the cycle after an edge at which `inValid` was high. All outputs update one edge after the inputs are sampled.
- R3: With `bcdMode`=0 and `subMode`=0, `sumZero` equals (A+B) mod 2^(4·DIGITS), and `carryZero` is the carry out of bit 4·DIGITS−1.
- R4: `sumOne` and `carryOne` are the sum and carry-out of the same addition with one added. In binary mode that is A+B'+1, where B' is B or ~B.
- R5: In binary mode `sumInv` is the bitwise inverse of `sumZero`. In BCD mode each digit of `sumInv` is nine minus the matching digit of `sumZero`.
- R6: With `bcdMode`=1 and `subMode`=0, `sumZero` holds the BCD digits of (A+B) mod 10^DIGITS, and `carryZero` is 1 exactly when A+B ≥ 10^DIGITS. This uses a +6 bias on each B digit, and a −6 fix on each digit that produced no carry.
- R7: In BCD mode, `sumOne` holds the BCD digits of (A+B'+1) mod 10^DIGITS, and `carryOne` is 1 exactly when A+B'+1 ≥ 10^DIGITS. B' is B, or the nines' complement of B when subtracting.
- R8: In binary mode with `subMode`=1, the adder uses ~B. `endCarry` is 1 exactly when A ≥ B, and `absDiff` equals |A−B|.
- R9: In BCD mode with `subMode`=1, each B digit is replaced by its nines' complement. `endCarry` is 1 exactly when A ≥ B, and `absDiff` holds the BCD digits of |A−B|.
- R10: When `subMode`=0, `endCarry` is 0 and `absDiff` equals `sumZero`.
- R11: At an edge where `inValid` is low, the result buses and carries keep their previous values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are sampled at this edge |
| bcdMode | input | 1 | 1: packed BCD digits, 0: plain binary |
| subMode | input | 1 | 1: effective subtraction |
| opA | input | 4·DIGITS | First mantissa |
| opB | input | 4·DIGITS | Second mantissa |
| resValid | output | 1 | Results below belong to the last sampled operands |
| sumZero | output | 4·DIGITS | Sum, carry-in 0 |
| sumOne | output | 4·DIGITS | Sum plus one |
| sumInv | output | 4·DIGITS | Inverted sum (nines' complement in BCD) |
| carryZero | output | 1 | Carry-out, carry-in 0 chain |
| carryOne | output | 1 | Carry-out, carry-in 1 chain |
| endCarry | output | 1 | End-around carry (A ≥ B on subtraction) |
| absDiff | output | 4·DIGITS | Sum on addition, magnitude of difference on subtraction |

## Verification
Directed vectors cover each mode in turn: plain nibble carries, a full ripple from all ones, a BCD sum of all nines plus one, and complementary BCD patterns whose sum is all nines, so that only the carry-in-1 chain ripples. Subtractions are run with A greater than B, B greater than A and A equal to B, in both radices. These separate the three branches of the end-around select, and the equal case tells a ≥ test from a > test. Random operands in all four mode combinations are compared against an integer reference in the bench. A hold test changes the operands with the strobe low, which shows whether the result registers ignore unsampled inputs.

// File: rtl/dual_radix_pkg.sv
package dual_radix_pkg;

  typedef struct packed {
    logic capture;    // load result registers this edge
    logic bcdMode;    // radix of current operands
    logic subMode;    // effective subtraction
    logic resultLive; // registered results are valid
  } addStrobe_t;

  // Digit post-correction: BCD digits that produced no carry lose the +6 bias.
  function automatic logic [3:0] fixDigit(input logic [3:0] raw, input logic carry,
                                          input logic bcd);
    return (bcd && !carry) ? raw - 4'd6 : raw;
  endfunction

  // Inverted digit: a biased BCD digit inverts to its nines' complement.
  function automatic logic [3:0] invDigit(input logic [3:0] raw, input logic carry,
                                          input logic bcd);
    logic [3:0] biased;
    biased = (bcd && carry) ? raw + 4'd6 : raw;
    return ~biased;
  endfunction

endpackage

// File: rtl/dual_radix_slice.sv
module dual_radix_slice (
  input  logic [3:0] aDigit,
  input  logic [3:0] bDigit,
  input  logic       bcdMode,
  input  logic       subMode,
  output logic [3:0] loZero,
  output logic [3:0] loOne,
  output logic       genOut,
  output logic       propOut
);
  logic [3:0] bPre;
  logic [4:0] wide;

  always_comb begin
    // Inverting a BCD digit already yields (9 - b) + 6, so subtraction needs no extra bias.
    if (subMode)      bPre = ~bDigit;
    else if (bcdMode) bPre = bDigit + 4'd6;
    else              bPre = bDigit;
    wide    = {1'b0, aDigit} + {1'b0, bPre};
    loZero  = wide[3:0];
    loOne   = wide[3:0] + 4'd1;
    genOut  = wide[4];
    propOut = (wide[3:0] == 4'hF);
  end
endmodule

// File: rtl/dual_radix_chain.sv
module dual_radix_chain #(
  parameter int DIGITS   = 8,
  parameter bit CARRY_IN = 1'b0
) (
  input  logic [DIGITS-1:0] gen,
  input  logic [DIGITS-1:0] prop,
  output logic [DIGITS:0]   carries
);
  always_comb begin
    carries[0] = CARRY_IN;
    for (int i = 0; i < DIGITS; i++) begin
      carries[i+1] = gen[i] | (prop[i] & carries[i]);
    end
  end
endmodule

// File: rtl/dual_radix_ctrl.sv
module dual_radix_ctrl
  import dual_radix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       bcdMode,
  input  logic       subMode,
  output addStrobe_t strobe,
  output logic       resValid
);
  logic liveQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) liveQ <= 1'b0;
    else        liveQ <= inValid;
  end

  always_comb begin
    strobe.capture    = inValid;
    strobe.bcdMode    = bcdMode;
    strobe.subMode    = subMode;
    strobe.resultLive = liveQ;
  end

  assign resValid = liveQ;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> resValid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !resValid);
endmodule

// File: rtl/dual_radix_datapath.sv
module dual_radix_datapath
  import dual_radix_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int WIDTH = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  addStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumZero,
  output logic [WIDTH-1:0] sumOne,
  output logic [WIDTH-1:0] sumInv,
  output logic             carryZero,
  output logic             carryOne,
  output logic             endCarry,
  output logic [WIDTH-1:0] absDiff
);
  logic [DIGITS-1:0] gen, prop;
  logic [3:0]        loZero [DIGITS];
  logic [3:0]        loOne  [DIGITS];
  logic [DIGITS:0]   chainZero, chainOne;
  logic [WIDTH-1:0]  hZero, hOne, hInv, pick;
  logic              eacNext;

  logic [WIDTH-1:0]  hZeroQ, hOneQ, hInvQ, pickQ;
  logic              cZeroQ, cOneQ, eacQ, bcdQ, subQ;

  for (genvar d = 0; d < DIGITS; d++) begin : g_slice
    dual_radix_slice u_slice (
      .aDigit (opA[4*d +: 4]),
      .bDigit (opB[4*d +: 4]),
      .bcdMode(strobe.bcdMode),
      .subMode(strobe.subMode),
      .loZero (loZero[d]),
      .loOne  (loOne[d]),
      .genOut (gen[d]),
      .propOut(prop[d])
    );
  end

  dual_radix_chain #(.DIGITS(DIGITS), .CARRY_IN(1'b0)) u_chain_zero (
    .gen(gen), .prop(prop), .carries(chainZero));
  dual_radix_chain #(.DIGITS(DIGITS), .CARRY_IN(1'b1)) u_chain_one (
    .gen(gen), .prop(prop), .carries(chainOne));

  for (genvar d = 0; d < DIGITS; d++) begin : g_select
    logic [3:0] rawZero, rawOne;
    always_comb begin
      rawZero = chainZero[d] ? loOne[d] : loZero[d];
      rawOne  = chainOne[d]  ? loOne[d] : loZero[d];
      hZero[4*d +: 4] = fixDigit(rawZero, chainZero[d+1], strobe.bcdMode);
      hOne[4*d +: 4]  = fixDigit(rawOne,  chainOne[d+1],  strobe.bcdMode);
      hInv[4*d +: 4]  = invDigit(rawZero, chainZero[d+1], strobe.bcdMode);
    end
  end

  always_comb begin
    eacNext = strobe.subMode & chainOne[DIGITS];
    if (!strobe.subMode) pick = hZero;
    else if (eacNext)    pick = hOne;
    else                 pick = hInv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hZeroQ <= '0; hOneQ <= '0; hInvQ <= '0; pickQ <= '0;
      cZeroQ <= 1'b0; cOneQ <= 1'b0; eacQ <= 1'b0; bcdQ <= 1'b0; subQ <= 1'b0;
    end else if (strobe.capture) begin
      hZeroQ <= hZero;
      hOneQ  <= hOne;
      hInvQ  <= hInv;
      pickQ  <= pick;
      cZeroQ <= chainZero[DIGITS];
      cOneQ  <= chainOne[DIGITS];
      eacQ   <= eacNext;
      bcdQ   <= strobe.bcdMode;
      subQ   <= strobe.subMode;
    end
  end

  assign sumZero   = hZeroQ;
  assign sumOne    = hOneQ;
  assign sumInv    = hInvQ;
  assign carryZero = cZeroQ;
  assign carryOne  = cOneQ;
  assign endCarry  = eacQ;
  assign absDiff   = pickQ;

  // R5: binary inverse relation between separately corrected registers
  p_inv_binary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.resultLive && !bcdQ) |-> (hInvQ == ~hZeroQ));

  for (genvar d = 0; d < DIGITS; d++) begin : g_nines_chk
    // R5: each BCD digit pair sums to nine
    p_inv_nines_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.resultLive && bcdQ) |->
        (({1'b0, hInvQ[4*d +: 4]} + {1'b0, hZeroQ[4*d +: 4]}) == 5'd9));
  end

  p_step_binary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.resultLive && !bcdQ) |-> (hOneQ == hZeroQ + 1'b1));

  p_abs_pick_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.resultLive && subQ && !eacQ) |-> (pickQ == hInvQ));

  p_add_no_eac_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.resultLive && !subQ) |-> (!eacQ && pickQ == hZeroQ));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> ($stable(hZeroQ) && $stable(pickQ) && $stable(cOneQ)));
endmodule

// File: rtl/dual_radix_adder.sv
module dual_radix_adder
  import dual_radix_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int WIDTH = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             bcdMode,
  input  logic             subMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             resValid,
  output logic [WIDTH-1:0] sumZero,
  output logic [WIDTH-1:0] sumOne,
  output logic [WIDTH-1:0] sumInv,
  output logic             carryZero,
  output logic             carryOne,
  output logic             endCarry,
  output logic [WIDTH-1:0] absDiff
);
  addStrobe_t strobe;

  dual_radix_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .bcdMode(bcdMode),
    .subMode(subMode), .strobe(strobe), .resValid(resValid));

  dual_radix_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opA(opA), .opB(opB),
    .sumZero(sumZero), .sumOne(sumOne), .sumInv(sumInv),
    .carryZero(carryZero), .carryOne(carryOne), .endCarry(endCarry),
    .absDiff(absDiff));
endmodule

// File: tb/dual_radix_adder_tb.sv
module dual_radix_adder_tb;
  localparam int DIGITS = 8;
  localparam int WIDTH  = 4 * DIGITS;
  localparam int PW     = 4 * WIDTH + 4;
  localparam longint MOD = 64'd100000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, bcdMode = 1'b0, subMode = 1'b0;
  logic [WIDTH-1:0] opA = '0, opB = '0;
  logic resValid, carryZero, carryOne, endCarry;
  logic [WIDTH-1:0] sumZero, sumOne, sumInv, absDiff;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  dual_radix_adder #(.DIGITS(DIGITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .bcdMode(bcdMode), .subMode(subMode),
    .opA(opA), .opB(opB), .resValid(resValid), .sumZero(sumZero), .sumOne(sumOne),
    .sumInv(sumInv), .carryZero(carryZero), .carryOne(carryOne), .endCarry(endCarry),
    .absDiff(absDiff));

  // {bcd, sub, A, B}
  localparam logic [65:0] VEC [13] = '{
    {2'b00, 32'h0000_0001, 32'h0000_0002},
    {2'b00, 32'hFFFF_FFFF, 32'h0000_0001},
    {2'b00, 32'h0000_000F, 32'h0000_0001},
    {2'b01, 32'h0000_1000, 32'h0000_0001},
    {2'b01, 32'h0000_0005, 32'h0000_0009},
    {2'b01, 32'h1234_5678, 32'h1234_5678},
    {2'b10, 32'h0000_0005, 32'h0000_0005},
    {2'b10, 32'h9999_9999, 32'h0000_0001},
    {2'b10, 32'h4545_4545, 32'h5454_5454},
    {2'b11, 32'h0000_1000, 32'h0000_0001},
    {2'b11, 32'h0000_0003, 32'h0000_0008},
    {2'b11, 32'h8765_4321, 32'h8765_4321},
    {2'b10, 32'h0000_0000, 32'h0000_0000}
  };

  function automatic longint bcdToInt(input logic [WIDTH-1:0] v);
    longint r = 0;
    for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] intToBcd(input longint v);
    logic [WIDTH-1:0] r = '0;
    longint t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // Packing: {valid, c0, c1, eac, h0, h1, hc, abs}
  function automatic logic [PW-1:0] refModel(input logic bcd, input logic sub,
                                             input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] h0, h1, hc, ab;
    logic c0, c1, eac;
    if (!bcd) begin
      logic [WIDTH:0] s0, s1;
      logic [WIDTH-1:0] bx;
      bx = sub ? ~b : b;
      s0 = {1'b0, a} + {1'b0, bx};
      s1 = s0 + 1'b1;
      h0 = s0[WIDTH-1:0]; c0 = s0[WIDTH];
      h1 = s1[WIDTH-1:0]; c1 = s1[WIDTH];
      hc = ~h0;
    end else begin
      longint ai, bi, t0, t1;
      ai = bcdToInt(a);
      bi = sub ? (MOD - 1 - bcdToInt(b)) : bcdToInt(b);
      t0 = ai + bi; t1 = t0 + 1;
      h0 = intToBcd(t0 % MOD); c0 = (t0 >= MOD);
      h1 = intToBcd(t1 % MOD); c1 = (t1 >= MOD);
      hc = intToBcd(MOD - 1 - (t0 % MOD));
    end
    eac = sub & c1;
    ab  = !sub ? h0 : (eac ? h1 : hc);
    return {1'b1, c0, c1, eac, h0, h1, hc, ab};
  endfunction

  function automatic logic [PW-1:0] observed();
    return {resValid, carryZero, carryOne, endCarry, sumZero, sumOne, sumInv, absDiff};
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input logic bcd, input logic sub);
    if (!bcd && !sub) return "R3 R4 R5 R10";
    if (!bcd &&  sub) return "R4 R5 R8";
    if ( bcd && !sub) return "R6 R7 R5 R10";
    return "R7 R5 R9";
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic runOne(input logic bcd, input logic sub,
                        input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    @(negedge clk);
    inValid = 1'b1; bcdMode = bcd; subMode = sub; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    check(tagFor(bcd, sub), observed(), refModel(bcd, sub, a, b));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", observed(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", observed(), '0);

    for (int i = 0; i < 13; i++) begin
      runOne(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R2: valid only in the cycle after the strobe
    @(negedge clk);
    check("R2", {31'd0, resValid}, '0);

    // R11: operands change with strobe low, results held
    held = observed();
    opA = 32'h1111_1111; opB = 32'h2222_2222; bcdMode = 1'b0; subMode = 1'b1;
    @(negedge clk);
    check("R11", observed(), {1'b0, held[PW-2:0]});

    // Random vectors across all mode combinations
    for (int n = 0; n < 400; n++) begin
      logic bcd, sub;
      logic [WIDTH-1:0] a, b;
      bcd = n[0]; sub = n[1];
      for (int d = 0; d < DIGITS; d++) begin
        seed = nextRand(seed);
        a[4*d +: 4] = bcd ? 4'(seed % 10) : seed[3:0];
        seed = nextRand(seed);
        b[4*d +: 4] = bcd ? 4'(seed % 10) : seed[7:4];
      end
      runOne(bcd, sub, a, b);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule